// File: doc/BRIEF.md
# Packed Two-Entry Color Palette Memory

This block keeps a 256-color lookup palette as 128 words of 32 bits. Each word carries two 16-bit color entries. Software stores and fetches raw words through a simple word-indexed bus port. The display pipeline presents an 8-bit pixel index and receives a 24-bit RGB color one clock later.

Each 16-bit entry carries three 5-bit components and one intensity flag. The flag is kept in storage so that bus reads return it, but it never reaches the color output. Each component is widened to 8 bits by placing it in the upper five bits and clearing the lower three. A lookup and a bus write in the same cycle see the palette as it stood before the write.

On a register map where the palette appears at byte offsets 0x200 through 0x3FC, the word index is the byte offset minus 0x200, shifted right by two.

Top module: `pal_dual_entry_ram`

## Requirements
- R1: Word n holds palette entry 2n in bits [15:0] and entry 2n+1 in bits [31:16]; a pixel index p selects word p[7:1] and the half given by p[0] (0 = low half).
- R2: In an entry, red sits in bits [4:0], green in bits [9:5] and blue in bits [14:10]; the color output places red in pix_rgb[23:16], green in [15:8] and blue in [7:0].
- R3: Bit 15 of an entry (the intensity flag) has no effect on pix_rgb.
- R4: Each 5-bit component c becomes the 8-bit value {c, 3'b000}, so 5'h1F gives 8'hF8 and 5'h01 gives 8'h08.
- R5: bus_rdata, one clock after bus_idx is presented, equals the exact 32-bit value last written to that word, including bits 15 and 31.
- R6: The whole index range is reachable: word 0 serves entries 0 and 1, and word 127 serves entries 254 and 255.
- R7: pix_rgb changes only at the clock edge after a new pix_idx is presented, and then shows that entry.
- R8: A lookup or bus read in the same cycle as a write to the same word returns the previous contents; the new contents appear from the next cycle on.
- R9: While rst_n is low, every word clears to zero, so bus reads return 0 and every lookup returns black (24'h000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all words |
| bus_we | input | 1 | Write strobe for the bus port |
| bus_idx | input | 7 | Word index for bus write and bus read |
| bus_wdata | input | 32 | Raw word to store |
| bus_rdata | output | 32 | Raw word read, registered |
| pix_idx | input | 8 | Palette entry index for lookup |
| pix_rgb | output | 24 | Expanded color {red, green, blue}, registered path |

## Verification
A corrupted word shows on bus_rdata one clock after its index is presented. It also shows on pix_rgb for either of the two entries that word serves, so a swapped half, a misplaced component field or a leaked intensity bit is caught by the first lookup of a word with distinct fields. Errors in read timing, such as returning the written data in the same cycle or a lookup that changes before the clock edge, show within one clock of the colliding write or the index change. A missed reset shows at the first read after reset is released.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
   // Component order inside an entry, lowest field first.
   typedef enum int {
      COMP_RED   = 0,
      COMP_GREEN = 1,
      COMP_BLUE  = 2
   } comp_e;

   localparam int COMP_COUNT   = 3;
   localparam int HALVES       = 2;

   // Place a component in the output word: red highest, blue lowest.
   function automatic int out_slot(input int comp);
      return COMP_COUNT - 1 - comp;
   endfunction
endpackage

// File: rtl/pal_word_store.sv
`timescale 1ns/1ps
module pal_word_store #(
   parameter int WORDS  = 128,
   parameter int DATA_W = 32,
   parameter int ADDR_W = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_a_i,
   output logic [DATA_W-1:0] rdata_a_o,
   input  logic [ADDR_W-1:0] raddr_b_i,
   output logic [DATA_W-1:0] rdata_b_o
);
   logic [DATA_W-1:0] mem_q [WORDS];

   // Storage with full clear on reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   // Two registered read ports; both see pre-write contents on a collision.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_a_o <= '0;
         rdata_b_o <= '0;
      end else begin
         rdata_a_o <= mem_q[raddr_a_i];
         rdata_b_o <= mem_q[raddr_b_i];
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i)); // R5

   AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i ##1 raddr_a_i == $past(raddr_a_i)) |=> $stable(rdata_a_o)); // R5
endmodule

// File: rtl/pal_half_pick.sv
`timescale 1ns/1ps
module pal_half_pick #(
   parameter int ENTRY_W = 16,
   parameter int COLOR_W = ENTRY_W - 1,
   parameter int DATA_W  = 2 * ENTRY_W
) (
   input  logic [DATA_W-1:0]  word_i,
   input  logic               sel_hi_i,
   output logic [COLOR_W-1:0] color_o
);
   import pal_pkg::*;

   logic [COLOR_W-1:0] half_color [HALVES];
   logic [HALVES-1:0]  intens_unused;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign half_color[h]    = word_i[h*ENTRY_W +: COLOR_W];
      assign intens_unused[h] = word_i[h*ENTRY_W + COLOR_W];
   end

   logic intens_fold_unused;
   assign intens_fold_unused = ^intens_unused;

   assign color_o = sel_hi_i ? half_color[1] : half_color[0];
endmodule

// File: rtl/pal_color_expand.sv
`timescale 1ns/1ps
module pal_color_expand #(
   parameter int COMP_W  = 5,
   parameter int OUT_W   = 8,
   parameter int COLOR_W = 3 * COMP_W,
   parameter int RGB_W   = 3 * OUT_W
) (
   input  logic [COLOR_W-1:0] color_i,
   output logic [RGB_W-1:0]   rgb_o
);
   import pal_pkg::*;

   localparam int PAD_W = OUT_W - COMP_W;

   for (genvar c = 0; c < COMP_COUNT; c++) begin : g_comp
      logic [COMP_W-1:0] field;
      assign field = color_i[c*COMP_W +: COMP_W];
      if (PAD_W == 0) begin : g_same
         assign rgb_o[out_slot(c)*OUT_W +: OUT_W] = field;
      end else begin : g_shift
         assign rgb_o[out_slot(c)*OUT_W +: OUT_W] = {field, {PAD_W{1'b0}}};
      end
   end
endmodule

// File: rtl/pal_dual_entry_ram.sv
`timescale 1ns/1ps
module pal_dual_entry_ram #(
   parameter int WORDS   = 128,
   parameter int COMP_W  = 5,
   parameter int OUT_W   = 8,
   parameter int WIDX_W  = $clog2(WORDS),
   parameter int PIDX_W  = WIDX_W + 1,
   parameter int ENTRY_W = 3 * COMP_W + 1,
   parameter int DATA_W  = 2 * ENTRY_W,
   parameter int RGB_W   = 3 * OUT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [WIDX_W-1:0] bus_idx,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PIDX_W-1:0] pix_idx,
   output logic [RGB_W-1:0]  pix_rgb
);
   localparam int COLOR_W = ENTRY_W - 1;

   if (OUT_W < COMP_W) begin : g_bad_width
      $error("OUT_W must not be narrower than COMP_W");
   end
   if (WORDS < 2 || (1 << WIDX_W) != WORDS) begin : g_bad_depth
      $error("WORDS must be a power of two of at least 2");
   end
   if (ENTRY_W != 3 * COMP_W + 1 || DATA_W != 2 * ENTRY_W) begin : g_bad_pack
      $error("entry and word widths must follow COMP_W");
   end

   logic [DATA_W-1:0]  look_word;
   logic               sel_hi_q;
   logic [COLOR_W-1:0] look_color;

   pal_word_store #(
      .WORDS (WORDS),
      .DATA_W(DATA_W),
      .ADDR_W(WIDX_W)
   ) i_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (bus_we),
      .waddr_i  (bus_idx),
      .wdata_i  (bus_wdata),
      .raddr_a_i(bus_idx),
      .rdata_a_o(bus_rdata),
      .raddr_b_i(pix_idx[PIDX_W-1:1]),
      .rdata_b_o(look_word)
   );

   // Half select travels alongside the word read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_hi_q <= 1'b0;
      else        sel_hi_q <= pix_idx[0];
   end

   pal_half_pick #(
      .ENTRY_W(ENTRY_W),
      .COLOR_W(COLOR_W),
      .DATA_W (DATA_W)
   ) i_pick (
      .word_i  (look_word),
      .sel_hi_i(sel_hi_q),
      .color_o (look_color)
   );

   pal_color_expand #(
      .COMP_W (COMP_W),
      .OUT_W  (OUT_W),
      .COLOR_W(COLOR_W),
      .RGB_W  (RGB_W)
   ) i_expand (
      .color_i(look_color),
      .rgb_o  (pix_rgb)
   );

   AST_RESET_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pix_rgb == '0 && bus_rdata == '0)); // R9

   AST_LOOKUP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we ##1 pix_idx == $past(pix_idx)) |=> $stable(pix_rgb)); // R7
endmodule

// File: tb/test_pal_dual_entry_ram.sv
`timescale 1ns/1ps
module test_pal_dual_entry_ram;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [6:0]  bus_idx = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pal_dual_entry_ram i_pal_dual_entry_ram (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_we   (bus_we),
      .bus_idx  (bus_idx),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pix_idx  (pix_idx),
      .pix_rgb  (pix_rgb)
   );

   // {word index, raw data, half, expected color}
   localparam logic [63:0] VEC [0:8] = '{
      {7'd0,   32'h0000_001F, 1'b0, 24'hF80000},
      {7'd1,   32'h03E0_0000, 1'b1, 24'h00F800},
      {7'd2,   32'h0000_7C00, 1'b0, 24'h0000F8},
      {7'd127, 32'hFFFF_0000, 1'b1, 24'hF8F8F8},
      {7'd64,  32'h8000_0001, 1'b0, 24'h080000},
      {7'd64,  32'h8000_0001, 1'b1, 24'h000000},
      {7'd10,  32'h1234_5678, 1'b0, 24'hC098A8},
      {7'd10,  32'h1234_5678, 1'b1, 24'hA08820},
      {7'd5,   32'h7FFF_FFFF, 1'b0, 24'hF8F8F8}
   };

   task automatic check_rgb(input string req, input logic [23:0] exp);
      checks++;
      if (pix_rgb !== exp) begin
         errors++;
         $display("FAIL %s pix_rgb actual=%h expected=%h", req, pix_rgb, exp);
      end
   endtask

   task automatic check_rd(input string req, input logic [31:0] exp);
      checks++;
      if (bus_rdata !== exp) begin
         errors++;
         $display("FAIL %s bus_rdata actual=%h expected=%h", req, bus_rdata, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic put_word(input logic [6:0] w, input logic [31:0] d);
      bus_we = 1'b1; bus_idx = w; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic look(input logic [7:0] p, input logic [6:0] w);
      pix_idx = p; bus_idx = w;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      look(8'd7, 7'd3);
      check_rgb("R9 reset black", 24'h000000);
      check_rd("R9 reset word", 32'h0);

      for (int v = 0; v < 9; v++) begin
         put_word(VEC[v][63:57], VEC[v][56:25]);
         look({VEC[v][63:57], VEC[v][24]}, VEC[v][63:57]);
         check_rgb($sformatf("R1 R2 R4 R6 vector %0d", v), VEC[v][23:0]);
         check_rd($sformatf("R5 vector %0d", v), VEC[v][56:25]);
      end

      // R7: no change before the edge, new entry after it.
      pix_idx = 8'd0;
      #1;
      check_rgb("R7 before edge", 24'hF8F8F8);
      @(negedge clk);
      check_rgb("R7 after edge", 24'hF80000);

      // R8: same-cycle collision returns old data.
      bus_we = 1'b1; bus_idx = 7'd0; bus_wdata = 32'h0000_7C00; pix_idx = 8'd0;
      @(negedge clk);
      bus_we = 1'b0;
      check_rgb("R8 collision old color", 24'hF80000);
      check_rd("R8 collision old word", 32'h0000_001F);
      @(negedge clk);
      check_rgb("R8 new color next cycle", 24'h0000F8);
      check_rd("R8 new word next cycle", 32'h0000_7C00);

      // R3: intensity bit set or clear gives the same color.
      put_word(7'd20, 32'h0000_0421);
      look(8'd40, 7'd20);
      check_rgb("R3 intensity clear", 24'h080808);
      put_word(7'd20, 32'h0000_8421);
      look(8'd40, 7'd20);
      check_rgb("R3 intensity set", 24'h080808);
      check_rd("R5 intensity kept in word", 32'h0000_8421);

      // R6: highest entry index.
      look(8'd255, 7'd127);
      check_rgb("R6 entry 255", 24'hF8F8F8);

      // R9: reset mid-run clears stored words.
      rst_n = 1'b0;
      @(negedge clk);
      check_rgb("R9 in reset", 24'h000000);
      rst_n = 1'b1;
      look(8'd20, 7'd10);
      check_rgb("R9 cleared entry", 24'h000000);
      check_rd("R9 cleared word", 32'h0);

      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule